// File: doc/BRIEF.md
# Multi-Register Block Transfer Sequencer

This block executes one class of 16-bit instructions. Each instruction moves a group of general registers between a 16-entry, 32-bit register file and word-wide memory, one word per completed memory beat. The instruction arrives on a valid input and is taken whenever the block is idle. The block reads the base address from the register file once, at acceptance. It then steps through the registers in ascending order and drives a memory request with a ready handshake. Loaded words go straight into the register file, and stored words are taken straight from it.

There are two shapes of transfer. The quadrant forms always move the fixed group R4 to R7, and the base register is selected by the instruction. The run forms take their base from R0 and move every register from a selected first register up to R15. No form writes its base back. A one-cycle completion pulse marks the end of each instruction, and an illegal flag travels with that pulse when the register choice is one the encoding forbids. Illegal forms still run to completion.

Top module: `regblock_mover`

## Requirements
- R1: An instruction is taken when `instValid` is high, `busy` is low and `instWord[15:6]` equals 10'b0000000001; any other word leaves `busy` and `memReq` low.
- R2: `instWord[5:4]` selects the operation: 0 loads the quadrant, 1 stores the quadrant, 2 loads a run and 3 stores a run; `memWe` is high on every beat of a store and low on every beat of a load.
- R3: The quadrant forms transfer exactly R4, R5, R6 and R7, using as base the value of the register numbered by `instWord[3:0]`.
- R4: The run forms use the value of R0 as base and transfer from the register numbered by `instWord[3:0]` up to and including R15.
- R5: Beat k of an instruction (k = 0, 1, …) transfers register first+k at byte address base+4·k, so the lowest register sits at the base address.
- R6: The base is the value the base register held at acceptance, and the operation never writes that register unless it lies inside the transferred range of a load.
- R7: A beat completes in a cycle where `memReq` and `memReady` are both high; until then the address and direction stay unchanged. A load writes `memRdata` into the register file in that same cycle, and no register write happens outside such a cycle.
- R8: `busy` and `memReq` are high from the cycle after acceptance through the cycle of the last beat, and a valid instruction presented while `busy` is high is ignored.
- R9: `done` is high for exactly one cycle, the cycle after the last beat, and `busy` is low in that cycle.
- R10: `illegal` is high together with `done` when a run form names R0 or R15 as first register, or when a quadrant load takes its base from R4–R7. The transfer still runs: first register R0 moves 16 words and R15 moves one. Otherwise `illegal` stays low.
- R11: A quadrant store whose base register is one of R4–R7 is not flagged illegal, and the word stored for that register is unspecified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction word is valid |
| instWord | input | 16 | Instruction word |
| busy | output | 1 | Transfer in progress; no instruction accepted |
| rfRdAddr | output | 4 | Register file read index |
| rfRdData | input | 32 | Register file read data (same cycle) |
| rfWrEn | output | 1 | Register file write enable |
| rfWrAddr | output | 4 | Register file write index |
| rfWrData | output | 32 | Register file write data |
| memReq | output | 1 | Memory beat requested |
| memWe | output | 1 | Beat is a write |
| memAddr | output | 32 | Byte address of the beat |
| memWdata | output | 32 | Write data of the beat |
| memRdata | input | 32 | Read data, valid while memReady is high |
| memReady | input | 1 | Memory completes the beat this cycle |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completed instruction used a forbidden register choice |

## Verification
A wrong register counter or address accumulator shows on `memAddr`, or on `rfWrAddr` of a load, on the very beat it goes wrong. The bench's model is compared on every clock, so such an error is reported in that cycle rather than at the end of the instruction. A wrong end-of-range or state error shows as an early or missing `done`, or as `busy` staying high, on the cycle after the expected last beat. A stale or corrupted latched base shifts every address of the instruction from its first beat. The final comparison of the register file and memory then catches any stray write, including a write to the base register.

// File: rtl/regblock_pkg.sv
`timescale 1ns/1ps
package regblock_pkg;
  localparam int INST_W = 16;
  localparam logic [9:0] XFER_PREFIX = 10'b0000000001;
  localparam int REG_N = 16;
  localparam int REG_AW = $clog2(REG_N);
  localparam int QUAD_FIRST = 4;
  localparam int QUAD_LEN = 4;

  typedef enum logic [1:0] {
    XOP_LOAD_QUAD  = 2'd0,
    XOP_STORE_QUAD = 2'd1,
    XOP_LOAD_RUN   = 2'd2,
    XOP_STORE_RUN  = 2'd3
  } xferOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic start;    // latch base, first and last register
    logic active;   // transfer running
    logic beat;     // memory beat completes this cycle
    logic isStore;  // running op writes memory
  } dpCtl_t;
endpackage

// File: rtl/regblock_ctrl.sv
`timescale 1ns/1ps
module regblock_ctrl
  import regblock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instValid,
  input  logic [INST_W-1:0] instWord,
  input  logic              memReady,
  input  logic              atLast,
  output dpCtl_t            ctl,
  output logic [REG_AW-1:0] decFirst,
  output logic [REG_AW-1:0] decLast,
  output logic [REG_AW-1:0] decBase,
  output logic              busy,
  output logic              memReq,
  output logic              memWe,
  output logic              done,
  output logic              illegal
);
  localparam logic [REG_AW-1:0] QUAD_LO  = REG_AW'(QUAD_FIRST);
  localparam logic [REG_AW-1:0] QUAD_HI  = REG_AW'(QUAD_FIRST + QUAD_LEN - 1);
  localparam logic [REG_AW-1:0] REG_TOP  = REG_AW'(REG_N - 1);

  typedef enum logic {S_IDLE, S_RUN} state_e;

  state_e            state;
  logic              storeQ;
  logic              illQ;
  logic              hit;
  logic              isQuad;
  logic              decIll;
  logic              startNow;
  logic              beatNow;
  logic              finishNow;
  xferOp_e           op;
  logic [REG_AW-1:0] fld;

  always_comb begin
    hit    = (instWord[INST_W-1:6] == XFER_PREFIX);
    op     = xferOp_e'(instWord[5:4]);
    fld    = instWord[REG_AW-1:0];
    isQuad = (op == XOP_LOAD_QUAD) || (op == XOP_STORE_QUAD);
    decFirst = isQuad ? QUAD_LO : fld;
    decLast  = isQuad ? QUAD_HI : REG_TOP;
    decBase  = isQuad ? fld : '0;
    if (isQuad) decIll = (op == XOP_LOAD_QUAD) && (fld >= QUAD_LO) && (fld <= QUAD_HI);
    else        decIll = (fld == '0) || (fld == REG_TOP);
    startNow  = (state == S_IDLE) && instValid && hit;
    beatNow   = (state == S_RUN) && memReady;
    finishNow = beatNow && atLast;
  end

  assign busy   = (state == S_RUN);
  assign memReq = busy;
  assign memWe  = busy && storeQ;
  assign ctl    = '{start: startNow, active: busy, beat: beatNow, isStore: storeQ};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      storeQ  <= 1'b0;
      illQ    <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= finishNow;
      illegal <= finishNow && illQ;
      if (startNow) begin
        state  <= S_RUN;
        storeQ <= instWord[4];
        illQ   <= decIll;
      end else if (finishNow) begin
        state <= S_IDLE;
      end
    end
  end
endmodule

// File: rtl/regblock_dpath.sv
`timescale 1ns/1ps
module regblock_dpath
  import regblock_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            ctl,
  input  logic [REG_AW-1:0] decFirst,
  input  logic [REG_AW-1:0] decLast,
  input  logic [REG_AW-1:0] decBase,
  input  logic [DATA_W-1:0] rfRdData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [REG_AW-1:0] rfRdAddr,
  output logic              rfWrEn,
  output logic [REG_AW-1:0] rfWrAddr,
  output logic [DATA_W-1:0] rfWrData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              atLast
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  logic [REG_AW-1:0] curReg;
  logic [REG_AW-1:0] lastReg;
  logic [ADDR_W-1:0] addrQ;

  // base is copied into the address accumulator once, at acceptance
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curReg  <= '0;
      lastReg <= '0;
      addrQ   <= '0;
    end else if (ctl.start) begin
      curReg  <= decFirst;
      lastReg <= decLast;
      addrQ   <= ADDR_W'(rfRdData);
    end else if (ctl.beat) begin
      curReg  <= curReg + 1'b1;
      addrQ   <= addrQ + STEP;
    end
  end

  assign rfRdAddr = ctl.active ? curReg : decBase;
  assign atLast   = (curReg == lastReg);
  assign rfWrEn   = ctl.beat && !ctl.isStore;
  assign rfWrAddr = curReg;
  assign rfWrData = memRdata;
  assign memAddr  = addrQ;
  assign memWdata = rfRdData;
endmodule

// File: rtl/regblock_mover.sv
`timescale 1ns/1ps
module regblock_mover
  import regblock_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instValid,
  input  logic [INST_W-1:0] instWord,
  output logic              busy,
  output logic [REG_AW-1:0] rfRdAddr,
  input  logic [DATA_W-1:0] rfRdData,
  output logic              rfWrEn,
  output logic [REG_AW-1:0] rfWrAddr,
  output logic [DATA_W-1:0] rfWrData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady,
  output logic              done,
  output logic              illegal
);
  dpCtl_t            ctl;
  logic [REG_AW-1:0] decFirst;
  logic [REG_AW-1:0] decLast;
  logic [REG_AW-1:0] decBase;
  logic              atLast;

  regblock_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .instValid (instValid),
    .instWord  (instWord),
    .memReady  (memReady),
    .atLast    (atLast),
    .ctl       (ctl),
    .decFirst  (decFirst),
    .decLast   (decLast),
    .decBase   (decBase),
    .busy      (busy),
    .memReq    (memReq),
    .memWe     (memWe),
    .done      (done),
    .illegal   (illegal)
  );

  regblock_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .decFirst (decFirst),
    .decLast  (decLast),
    .decBase  (decBase),
    .rfRdData (rfRdData),
    .memRdata (memRdata),
    .rfRdAddr (rfRdAddr),
    .rfWrEn   (rfWrEn),
    .rfWrAddr (rfWrAddr),
    .rfWrData (rfWrData),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .atLast   (atLast)
  );
endmodule

// File: rtl/regblock_mover_chk.sv
`timescale 1ns/1ps
module regblock_mover_chk
  import regblock_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instValid,
  input logic [INST_W-1:0] instWord,
  input logic              busy,
  input logic              rfWrEn,
  input logic [REG_AW-1:0] rfWrAddr,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memReady,
  input logic              done,
  input logic              illegal
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  logic takeNow;
  assign takeNow = !busy && instValid && (instWord[INST_W-1:6] == XFER_PREFIX);

  AST_ACCEPT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    takeNow |=> busy); // R1
  AST_IGNORE_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !takeNow) |=> !busy); // R1
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memReady) |=> (!memReq || memAddr == $past(memAddr) + STEP)); // R5
  AST_WRITE_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (rfWrEn && $past(rfWrEn)) |-> (rfWrAddr == $past(rfWrAddr) + 1'b1)); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe))); // R7
  AST_WRITE_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    rfWrEn |-> (memReq && memReady && !memWe)); // R7
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !memReq); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_END_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R9
  AST_ILLEGAL_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done); // R10
endmodule

bind regblock_mover regblock_mover_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/regblock_mover_tb.sv
`timescale 1ns/1ps
module regblock_mover_tb;
  import regblock_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instValid;
  logic [15:0] instWord;
  logic        busy;
  logic [3:0]  rfRdAddr;
  logic [31:0] rfRdData;
  logic        rfWrEn;
  logic [3:0]  rfWrAddr;
  logic [31:0] rfWrData;
  logic        memReq;
  logic        memWe;
  logic [31:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata;
  logic        memReady;
  logic        done;
  logic        illegal;

  logic [31:0] rf  [16];
  logic [31:0] mem [256];

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  regblock_mover u_dut (
    .clk(clk), .rst_n(rst_n), .instValid(instValid), .instWord(instWord), .busy(busy),
    .rfRdAddr(rfRdAddr), .rfRdData(rfRdData), .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr),
    .rfWrData(rfWrData), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady), .done(done),
    .illegal(illegal)
  );

  // environment: register file and memory
  assign rfRdData = rf[rfRdAddr];
  assign memRdata = mem[memAddr[9:2]];
  always @(posedge clk) begin
    if (rfWrEn) rf[rfWrAddr] <= rfWrData;
    if (memReq && memReady && memWe) mem[memAddr[9:2]] <= memWdata;
  end

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  idx;
    bit          skip;
  } beat_t;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic setReg(input int idx, input logic [31:0] val);
    @(negedge clk);
    rf[idx] <= val;
  endtask

  task automatic runInst(input logic [15:0] w, input bit randReady, input bit poke);
    beat_t       q[$];
    logic [31:0] expRf [16];
    logic [31:0] expMem [256];
    bit          store = w[4];
    bit          quad  = !w[5];
    int          fld   = int'(w[3:0]);
    int          first = quad ? 4 : fld;
    int          last  = quad ? 7 : 15;
    int          bIdx  = quad ? fld : 0;
    bit          baseInQuad = (fld >= 4) && (fld <= 7);
    bit          expIll = quad ? (!store && baseInQuad) : (fld == 0 || fld == 15);
    string       formReq = quad ? "R3" : "R4";
    string       illReq  = (quad && store && baseInQuad) ? "R11" : "R10";
    int          skipMem = -1;
    int          bad;
    logic [31:0] base;

    @(negedge clk); #1;
    base = rf[bIdx];
    for (int i = 0; i < 16; i++) expRf[i] = rf[i];
    for (int i = 0; i < 256; i++) expMem[i] = mem[i];
    for (int r = first; r <= last; r++) begin
      beat_t b;
      b.addr = base + 32'(4 * (r - first));
      b.idx  = 4'(r);
      b.skip = store && quad && (bIdx == r);
      b.data = store ? rf[r] : mem[b.addr[9:2]];
      if (b.skip) skipMem = int'(b.addr[9:2]);
      if (store) expMem[b.addr[9:2]] = b.data;
      else       expRf[r] = b.data;
      q.push_back(b);
    end
    chk(busy === 1'b0 && memReq === 1'b0 && done === 1'b0, "R8", "idle before issue",
        {busy, memReq, done}, 32'd0);
    instWord  = w;
    instValid = 1'b1;
    memReady  = 1'b0;
    @(negedge clk);
    forever begin
      memReady = randReady ? 1'($urandom_range(0, 1)) : 1'b1;
      if (q.size() > 0) begin
        // a second instruction offered while busy must be ignored (R8)
        instValid = poke && !(q.size() == 1 && memReady);
        instWord  = 16'h0062;
        #1;
        chk(busy === 1'b1, "R8", "busy during transfer", busy, 1);
        chk(memReq === 1'b1, "R8", "request during transfer", memReq, 1);
        chk(memWe === store, "R2", "beat direction", memWe, store);
        chk(memAddr === q[0].addr, "R5", "beat address", memAddr, q[0].addr);
        if (store && !q[0].skip)
          chk(memWdata === q[0].data, formReq, "store data", memWdata, q[0].data);
        chk(rfWrEn === (!store && memReady), "R7", "register write strobe", rfWrEn,
            (!store && memReady));
        if (!store && memReady) begin
          chk(rfWrAddr === q[0].idx, "R5", "load target register", rfWrAddr, q[0].idx);
          chk(rfWrData === q[0].data, formReq, "load data", rfWrData, q[0].data);
        end
        chk(done === 1'b0 && illegal === 1'b0, "R9", "no completion mid-transfer",
            {done, illegal}, 32'd0);
        if (memReady) void'(q.pop_front());
      end else begin
        instValid = 1'b0;
        #1;
        chk(done === 1'b1, "R9", "completion pulse", done, 1);
        chk(busy === 1'b0, "R9", "idle at completion", busy, 0);
        chk(illegal === expIll, illReq, "illegal flag", illegal, expIll);
        break;
      end
      @(negedge clk);
    end
    memReady = 1'b0;
    @(negedge clk); #1;
    chk(done === 1'b0 && busy === 1'b0, "R9", "single completion pulse", {busy, done}, 32'd0);
    if (!(!store && expIll)) begin
      bad = 0;
      for (int i = 0; i < 16; i++) if (rf[i] !== expRf[i]) bad++;
      chk(bad == 0, "R6", "register file contents", bad, 0);
    end
    bad = 0;
    for (int i = 0; i < 256; i++) if (i != skipMem && mem[i] !== expMem[i]) bad++;
    chk(bad == 0, "R5", "memory contents", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    instValid = 1'b0;
    instWord  = 16'h0000;
    memReady  = 1'b0;
    for (int i = 0; i < 16; i++) rf[i] <= $urandom;
    for (int i = 0; i < 256; i++) mem[i] <= $urandom;
    repeat (3) @(negedge clk);
    #1;
    chk(busy === 1'b0 && memReq === 1'b0 && rfWrEn === 1'b0, "R8", "reset outputs",
        {busy, memReq, rfWrEn}, 32'd0);
    chk(done === 1'b0 && illegal === 1'b0, "R9", "reset status", {done, illegal}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: words outside the prefix are ignored
    foreach (instWord[i]) begin end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      instWord  = (k == 0) ? 16'h0080 : (k == 1) ? 16'h00C5 : 16'h0000;
      instValid = 1'b1;
      @(negedge clk); #1;
      chk(busy === 1'b0 && memReq === 1'b0, "R1", "non-matching word ignored",
          {busy, memReq}, 32'd0);
      instValid = 1'b0;
    end

    // quadrant forms with a legal base
    setReg(2, $urandom & 32'hFFFF_FFFC);
    runInst(16'h0042, 1'b0, 1'b0);
    setReg(9, $urandom & 32'hFFFF_FFFC);
    runInst(16'h0059, 1'b1, 1'b1);
    for (int k = 0; k < 4; k++) begin
      int b = (k == 0) ? 0 : (k == 1) ? 3 : (k == 2) ? 11 : 15;
      setReg(b, $urandom & 32'hFFFF_FFFC);
      runInst(16'h0040 | 16'(b), 1'b1, 1'b0);
      setReg(b, $urandom & 32'hFFFF_FFFC);
      runInst(16'h0050 | 16'(b), 1'b1, 1'b0);
    end
    // address wrap at the top of the space
    setReg(1, 32'hFFFF_FFF8);
    runInst(16'h0041, 1'b0, 1'b0);

    // run forms over every legal first register
    for (int f = 1; f <= 14; f++) begin
      setReg(0, $urandom & 32'hFFFF_FFFC);
      runInst(16'h0070 | 16'(f), 1'b1, f == 5);
      setReg(0, $urandom & 32'hFFFF_FFFC);
      runInst(16'h0060 | 16'(f), f[0], 1'b0);
    end

    // forbidden register choices (R10) and the unflagged store case (R11)
    setReg(0, $urandom & 32'hFFFF_FFFC);
    runInst(16'h0070, 1'b1, 1'b0);
    setReg(0, $urandom & 32'hFFFF_FFFC);
    runInst(16'h007F, 1'b0, 1'b0);
    setReg(0, $urandom & 32'hFFFF_FFFC);
    runInst(16'h006F, 1'b1, 1'b0);
    setReg(0, $urandom & 32'hFFFF_FFFC);
    runInst(16'h0060, 1'b0, 1'b0);
    setReg(5, $urandom & 32'hFFFF_FFFC);
    runInst(16'h0045, 1'b1, 1'b0);
    setReg(6, $urandom & 32'hFFFF_FFFC);
    runInst(16'h0056, 1'b1, 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule